// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a small CPU and decides when the CPU is to be interrupted. Each peripheral source sends a one-cycle request pulse, which the block holds as a pending flag until it is serviced or cleared. A pending maskable flag is eligible for service only while its own enable input and the CPU's global enable bit are both high. A non-maskable request and a reset request bypass both enables.

When the CPU reports an instruction boundary and something is eligible, the block runs a fixed entry sequence. It pushes the return PC, pushes the status register, picks the highest-priority request and clears its flag if the source owns its vector alone, strobes a status-register clear, and then loads the vector address into the PC. A return request runs the reverse: the status register is popped first, then the PC. A reset request is taken asynchronously. It aborts any sequence in progress and loads the reset vector with no stack traffic. The same happens once after the active-low reset is released.

Vector addresses are fixed and fall by two per priority step. Reset uses 0xFFFE and the non-maskable request uses 0xFFFC. Maskable source i uses 0xFFFA − 2·i, so source 0 is the highest maskable priority and the table ends at 0xFFC0 (at most 30 sources).

Top module: `irq_vector_ctrl`

## Requirements
- R1: Maskable source i is serviced only when its flag is pending, src_en[i] is 1 and gie is 1, and its vector is 0xFFFA − 2·i (source 2 gives 0xFFF6, source 6 gives 0xFFEE).
- R2: A non-maskable request is serviced even with gie at 0, uses vector 0xFFFC, and outranks every pending maskable source.
- R3: When several maskable sources are eligible together, the lowest index is serviced first and the others stay pending.
- R4: A request that arrives while gie or its own enable is 0 stays visible on pend_flags and is serviced after enabling allows it.
- R5: When the controller is idle and instr_done is 1 at an edge with an eligible request, the outputs follow at fixed offsets after that edge. Offset 0 has stk_push with stk_sel=0 (PC). Offset 1 has stk_push with stk_sel=1 (status). Offset 2 has int_taken. Offset 3 has sr_clr. Offset 4 has vec_load with the vector on vec_addr. The controller is idle again at offset 5.
- R6: At int_taken the serviced flag is cleared when the source has its own vector. A source marked in SHARED_SRC (by default the highest index) keeps its flag.
- R7: ret_req sampled high while idle yields stk_pop with stk_sel=1 at offset 0 and stk_pop with stk_sel=0 at offset 1. ret_req is honoured before a same-cycle entry.
- R8: No entry starts without instr_done. A request arriving during a sequence waits for a later boundary, unless it outranks the pending one before the selection step.
- R9: Writing flag_clr with flag_clr_we=1 clears the marked flags at the next edge, but a src_pulse on the same bit in that cycle leaves the flag set.
- R10: After rst_n is released, and after any rst_req, the next edge yields vec_load with 0xFFFE and sr_clr in the same cycle, with no stack push. A sequence in progress is abandoned and its request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| src_pulse | input | N_SRC | One-cycle request pulse per maskable source |
| src_en | input | N_SRC | Per-source enable |
| gie | input | 1 | Global enable bit from the CPU status register |
| nmi_req | input | 1 | Non-maskable request pulse |
| rst_req | input | 1 | Asynchronous reset-vector request |
| instr_done | input | 1 | CPU is at an instruction boundary |
| ret_req | input | 1 | CPU executes a return from interrupt |
| flag_clr_we | input | 1 | Software write strobe for flag clearing |
| flag_clr | input | N_SRC | Write-one-to-clear mask for pending flags |
| int_taken | output | 1 | Strobe in the cycle the request is selected |
| vec_load | output | 1 | Load vec_addr into the PC |
| vec_addr | output | 16 | Vector fetch address |
| stk_push | output | 1 | Stack push request |
| stk_pop | output | 1 | Stack pop request |
| stk_sel | output | 1 | Stack data select: 0 PC, 1 status register |
| sr_clr | output | 1 | Clear the status register |
| busy | output | 1 | A sequence is in progress |
| pend_flags | output | N_SRC | Pending maskable flags |

## Verification
Every result has a fixed due cycle. Flag changes appear one edge after the pulse or write. Entry strobes fall at offsets 0 to 4 after the accepting edge, pops at offsets 0 and 1 after the return edge, and the reset vector at the first edge after the request. The driver stamps each expected strobe with its due cycle and pushes it into a queue. The monitor samples on the falling clock edge, pops one item per observed strobe, and compares the kind, the vector and the cycle number. Any strobe with no item waiting counts as a failure, so the windows where a masked or unbounded request must stay silent are covered.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_SELECT,
    ST_CLR_SR,
    ST_LOAD,
    ST_POP_SR,
    ST_POP_PC,
    ST_RVEC
  } ivc_state_e;

  localparam logic [15:0] VEC_RESET    = 16'hFFFE;
  localparam logic [15:0] VEC_NMI      = 16'hFFFC;
  localparam logic [15:0] VEC_TBL_BASE = 16'hFFC0;

  localparam logic STK_SEL_PC = 1'b0;
  localparam logic STK_SEL_SR = 1'b1;

  // maskable source idx sits one priority step below the previous one
  function automatic logic [15:0] src_vec(input int unsigned idx);
    return VEC_NMI - 16'((idx + 1) * 2);
  endfunction

endpackage

// File: rtl/ivc_flag_bank.sv
module ivc_flag_bank #(
  parameter int unsigned       N_SRC      = 8,
  parameter logic [N_SRC-1:0]  SHARED_SRC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             sw_we_i,
  input  logic [N_SRC-1:0] sw_clr_i,
  input  logic [N_SRC-1:0] ack_oh_i,
  output logic [N_SRC-1:0] flags_o
);

  logic [N_SRC-1:0] flag_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_flag
    logic clr_hit;
    logic flag_ce;
    logic flag_d;

    // auto clear only for a source that owns its vector
    assign clr_hit = (sw_we_i & sw_clr_i[g]) | (ack_oh_i[g] & ~SHARED_SRC[g]);
    assign flag_ce = clr_hit | set_i[g];
    // a hardware set in the same cycle beats any clear
    assign flag_d  = set_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (flag_ce) begin
        flag_q[g] <= flag_d;
      end
    end
  end

  assign flags_o = flag_q;

endmodule

// File: rtl/ivc_prio_pick.sv
module ivc_prio_pick #(
  parameter int unsigned N_SRC = 8,
  localparam int unsigned IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDXW-1:0]  idx_o
);

  logic found;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    found = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && !found) begin
        idx_o = IDXW'(i);
        found = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/ivc_seq.sv
module ivc_seq
  import ivc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pend_i,
  input  logic ret_req_i,
  input  logic instr_done_i,
  input  logic any_req_i,
  output logic accept_o,
  output logic in_select_o,
  output logic in_rvec_o,
  output logic stk_push_o,
  output logic stk_pop_o,
  output logic stk_sel_o,
  output logic int_taken_o,
  output logic sr_clr_o,
  output logic vec_load_o,
  output logic busy_o
);

  ivc_state_e st_q;
  ivc_state_e st_d;

  // next-state process
  always_comb begin
    st_d = st_q;
    if (rst_pend_i && st_q != ST_RVEC) begin
      st_d = ST_RVEC;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ret_req_i)                      st_d = ST_POP_SR;
          else if (instr_done_i && any_req_i) st_d = ST_PUSH_PC;
        end
        ST_PUSH_PC: st_d = ST_PUSH_SR;
        ST_PUSH_SR: st_d = ST_SELECT;
        ST_SELECT:  st_d = ST_CLR_SR;
        ST_CLR_SR:  st_d = ST_LOAD;
        ST_LOAD:    st_d = ST_IDLE;
        ST_POP_SR:  st_d = ST_POP_PC;
        ST_POP_PC:  st_d = ST_IDLE;
        ST_RVEC:    st_d = ST_IDLE;
        default:    st_d = ST_IDLE;
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign accept_o    = (st_q == ST_IDLE) && (st_d == ST_PUSH_PC);
  assign in_select_o = (st_q == ST_SELECT);
  assign in_rvec_o   = (st_q == ST_RVEC);
  assign stk_push_o  = (st_q == ST_PUSH_PC) || (st_q == ST_PUSH_SR);
  assign stk_pop_o   = (st_q == ST_POP_SR)  || (st_q == ST_POP_PC);
  assign stk_sel_o   = ((st_q == ST_PUSH_SR) || (st_q == ST_POP_SR)) ? STK_SEL_SR : STK_SEL_PC;
  assign int_taken_o = (st_q == ST_SELECT);
  assign sr_clr_o    = (st_q == ST_CLR_SR) || (st_q == ST_RVEC);
  assign vec_load_o  = (st_q == ST_LOAD)   || (st_q == ST_RVEC);
  assign busy_o      = (st_q != ST_IDLE);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter int unsigned      N_SRC      = 8,
  parameter logic [N_SRC-1:0] SHARED_SRC = {1'b1, {(N_SRC-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie,
  input  logic             nmi_req,
  input  logic             rst_req,
  input  logic             instr_done,
  input  logic             ret_req,
  input  logic             flag_clr_we,
  input  logic [N_SRC-1:0] flag_clr,
  output logic             int_taken,
  output logic             vec_load,
  output logic [15:0]      vec_addr,
  output logic             stk_push,
  output logic             stk_pop,
  output logic             stk_sel,
  output logic             sr_clr,
  output logic             busy,
  output logic [N_SRC-1:0] pend_flags
);

  localparam int unsigned IDXW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] flags;
  logic [N_SRC-1:0] elig;
  logic [N_SRC-1:0] ack_oh;
  logic             m_any;
  logic [IDXW-1:0]  m_idx;
  logic             any_req;
  logic             nmi_pend_q;
  logic             rst_pend_q;
  logic             accept;
  logic             in_select;
  logic             in_rvec;
  logic             acc_nmi_q;
  logic [IDXW-1:0]  acc_idx_q;
  logic             sel_nmi;
  logic [IDXW-1:0]  sel_idx;
  logic             win_nmi_q;
  logic [IDXW-1:0]  win_idx_q;
  logic [15:0]      win_vec;

  ivc_flag_bank #(
    .N_SRC      (N_SRC),
    .SHARED_SRC (SHARED_SRC)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (src_pulse),
    .sw_we_i  (flag_clr_we),
    .sw_clr_i (flag_clr),
    .ack_oh_i (ack_oh),
    .flags_o  (flags)
  );

  assign elig = flags & src_en & {N_SRC{gie}};

  ivc_prio_pick #(
    .N_SRC (N_SRC)
  ) u_pick (
    .req_i (elig),
    .any_o (m_any),
    .idx_o (m_idx)
  );

  assign any_req = nmi_pend_q | m_any;

  ivc_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_pend_i   (rst_pend_q),
    .ret_req_i    (ret_req),
    .instr_done_i (instr_done),
    .any_req_i    (any_req),
    .accept_o     (accept),
    .in_select_o  (in_select),
    .in_rvec_o    (in_rvec),
    .stk_push_o   (stk_push),
    .stk_pop_o    (stk_pop),
    .stk_sel_o    (stk_sel),
    .int_taken_o  (int_taken),
    .sr_clr_o     (sr_clr),
    .vec_load_o   (vec_load),
    .busy_o       (busy)
  );

  // reset vector request: set asynchronously, consumed by the vector cycle
  always_ff @(posedge clk or negedge rst_n or posedge rst_req) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
    end else if (rst_req) begin
      rst_pend_q <= 1'b1;
    end else if (in_rvec) begin
      rst_pend_q <= 1'b0;
    end
  end

  // non-maskable latch: one source behind its vector, so cleared on selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend_q <= 1'b0;
    end else if (nmi_req) begin
      nmi_pend_q <= 1'b1;
    end else if (in_select && sel_nmi) begin
      nmi_pend_q <= 1'b0;
    end
  end

  // candidate at acceptance, used if nothing is eligible at selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_nmi_q <= 1'b0;
      acc_idx_q <= '0;
    end else if (accept) begin
      acc_nmi_q <= nmi_pend_q;
      acc_idx_q <= m_idx;
    end
  end

  always_comb begin
    if (nmi_pend_q) begin
      sel_nmi = 1'b1;
      sel_idx = m_idx;
    end else if (m_any) begin
      sel_nmi = 1'b0;
      sel_idx = m_idx;
    end else begin
      sel_nmi = acc_nmi_q;
      sel_idx = acc_idx_q;
    end
  end

  always_comb begin
    ack_oh = '0;
    for (int i = 0; i < N_SRC; i++) begin
      ack_oh[i] = in_select && !sel_nmi && (sel_idx == IDXW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_nmi_q <= 1'b0;
      win_idx_q <= '0;
    end else if (in_select) begin
      win_nmi_q <= sel_nmi;
      win_idx_q <= sel_idx;
    end
  end

  assign win_vec    = win_nmi_q ? VEC_NMI : src_vec(32'(win_idx_q));
  assign vec_addr   = in_rvec ? VEC_RESET : win_vec;
  assign pend_flags = flags;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int unsigned N_SRC = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] src_pulse,
  input logic             instr_done,
  input logic             int_taken,
  input logic             vec_load,
  input logic [15:0]      vec_addr,
  input logic             stk_push,
  input logic             stk_pop,
  input logic             stk_sel,
  input logic             sr_clr,
  input logic             busy,
  input logic [N_SRC-1:0] pend_flags
);

  AST_VEC_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (vec_addr >= 16'hFFC0) && !vec_addr[0]);  // R1

  AST_PUSH_SR_AFTER_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && stk_sel) |-> $past(stk_push && !stk_sel));  // R5

  AST_TAKEN_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    int_taken |-> $past(stk_push && stk_sel));  // R5

  AST_LOAD_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_load && vec_addr != 16'hFFFE) |-> ($past(sr_clr) && !sr_clr));  // R5

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stk_push, stk_pop, int_taken, vec_load && !sr_clr}));  // R5

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push || stk_pop || int_taken || vec_load || sr_clr) |-> busy);  // R5

  AST_POP_PC_AFTER_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_pop && !stk_sel) |-> $past(stk_pop && stk_sel));  // R7

  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_push && !stk_sel) |-> $past(instr_done));  // R8

  AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_flags & $past(src_pulse)) == $past(src_pulse)));  // R9

  AST_RESET_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_load && vec_addr == 16'hFFFE) |-> (sr_clr && !stk_push && !int_taken));  // R10

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .src_pulse  (src_pulse),
  .instr_done (instr_done),
  .int_taken  (int_taken),
  .vec_load   (vec_load),
  .vec_addr   (vec_addr),
  .stk_push   (stk_push),
  .stk_pop    (stk_pop),
  .stk_sel    (stk_sel),
  .sr_clr     (sr_clr),
  .busy       (busy),
  .pend_flags (pend_flags)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  localparam int K_PUSH_PC = 1;
  localparam int K_PUSH_SR = 2;
  localparam int K_POP_SR  = 3;
  localparam int K_POP_PC  = 4;
  localparam int K_TAKEN   = 5;
  localparam int K_SRCLR   = 6;
  localparam int K_LOAD    = 7;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_pulse;
  logic [N-1:0] src_en;
  logic         gie;
  logic         nmi_req;
  logic         rst_req;
  logic         instr_done;
  logic         ret_req;
  logic         flag_clr_we;
  logic [N-1:0] flag_clr;
  logic         int_taken;
  logic         vec_load;
  logic [15:0]  vec_addr;
  logic         stk_push;
  logic         stk_pop;
  logic         stk_sel;
  logic         sr_clr;
  logic         busy;
  logic [N-1:0] pend_flags;

  typedef struct {
    int          cyc;
    int          kind;
    logic [15:0] val;
    string       req;
  } ev_t;

  ev_t exp_q[$];
  int  n_chk = 0;
  int  n_err = 0;
  int  cyc   = 0;
  bit  done  = 1'b0;

  irq_vector_ctrl #(.N_SRC(N)) u_irq_vector_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pulse   (src_pulse),
    .src_en      (src_en),
    .gie         (gie),
    .nmi_req     (nmi_req),
    .rst_req     (rst_req),
    .instr_done  (instr_done),
    .ret_req     (ret_req),
    .flag_clr_we (flag_clr_we),
    .flag_clr    (flag_clr),
    .int_taken   (int_taken),
    .vec_load    (vec_load),
    .vec_addr    (vec_addr),
    .stk_push    (stk_push),
    .stk_pop     (stk_pop),
    .stk_sel     (stk_sel),
    .sr_clr      (sr_clr),
    .busy        (busy),
    .pend_flags  (pend_flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input int c, input int k, input logic [15:0] v, input string r);
    exp_q.push_back('{cyc: c, kind: k, val: v, req: r});
  endtask

  task automatic got(input int k, input logic [15:0] v);
    ev_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_err++;
      $display("FAIL R8 unexpected strobe: actual kind=%0d val=%h cyc=%0d expected none",
               k, v, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.val != v || e.cyc != cyc) begin
        n_err++;
        $display("FAIL %s strobe: actual kind=%0d val=%h cyc=%0d expected kind=%0d val=%h cyc=%0d",
                 e.req, k, v, cyc, e.kind, e.val, e.cyc);
      end
    end
  endtask

  // monitor: one item per observed strobe, fixed order within a cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (stk_push)  got(stk_sel ? K_PUSH_SR : K_PUSH_PC, 16'h0);
      if (stk_pop)   got(stk_sel ? K_POP_SR : K_POP_PC, 16'h0);
      if (int_taken) got(K_TAKEN, 16'h0);
      if (sr_clr)    got(K_SRCLR, 16'h0);
      if (vec_load)  got(K_LOAD, vec_addr);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_flags(input logic [N-1:0] e, input string r);
    check(pend_flags == e, r, "pend_flags", int'(pend_flags), int'(e));
  endtask

  task automatic pulse(input int i);
    src_pulse[i] = 1'b1;
    tick(1);
    src_pulse = '0;
  endtask

  task automatic expect_entry(input int a, input logic [15:0] v, input string r);
    expect_ev(a,     K_PUSH_PC, 16'h0, r);
    expect_ev(a + 1, K_PUSH_SR, 16'h0, r);
    expect_ev(a + 2, K_TAKEN,   16'h0, r);
    expect_ev(a + 3, K_SRCLR,   16'h0, r);
    expect_ev(a + 4, K_LOAD,    v,     r);
  endtask

  // boundary now; strobes at offsets 0..4 after the accepting edge (R5)
  task automatic take(input logic [15:0] v, input string r);
    int a;
    a = cyc + 1;
    instr_done = 1'b1;
    expect_entry(a, v, r);
    tick(1);
    instr_done = 1'b0;
    tick(5);
    check(busy == 1'b0, "R5", "busy after entry", int'(busy), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int a;
    rst_n = 1'b0; src_pulse = '0; src_en = '0; gie = 1'b0; nmi_req = 1'b0;
    rst_req = 1'b0; instr_done = 1'b0; ret_req = 1'b0; flag_clr_we = 1'b0; flag_clr = '0;
    tick(3);
    check(busy == 1'b0, "R10", "busy in reset", int'(busy), 0);
    chk_flags('0, "R10");
    // boot: reset vector one edge after release, no pushes (R10)
    a = cyc + 1;
    rst_n = 1'b1;
    expect_ev(a, K_SRCLR, 16'h0, "R10");
    expect_ev(a, K_LOAD, 16'hFFFE, "R10");
    tick(3);

    // R1 basic service and R6 auto clear
    src_en = '1; gie = 1'b1;
    pulse(2);
    chk_flags(8'h04, "R1");
    take(16'hFFF6, "R1");
    chk_flags(8'h00, "R6");

    // R4 global mask holds the request
    gie = 1'b0;
    pulse(3);
    instr_done = 1'b1; tick(4); instr_done = 1'b0;
    chk_flags(8'h08, "R4");
    gie = 1'b1;
    take(16'hFFF4, "R4");
    chk_flags(8'h00, "R4");

    // R4 source mask holds the request
    src_en[5] = 1'b0;
    pulse(5);
    instr_done = 1'b1; tick(3); instr_done = 1'b0;
    chk_flags(8'h20, "R4");
    src_en[5] = 1'b1;
    take(16'hFFF0, "R4");

    // R2 non-maskable ignores gie
    gie = 1'b0;
    nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
    take(16'hFFFC, "R2");
    gie = 1'b1;

    // R2 non-maskable outranks source 0
    pulse(0);
    nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
    take(16'hFFFC, "R2");
    chk_flags(8'h01, "R2");
    take(16'hFFFA, "R1");

    // R3 two eligible sources
    src_pulse = 8'h42; tick(1); src_pulse = '0;
    take(16'hFFF8, "R3");
    chk_flags(8'h40, "R3");
    take(16'hFFEE, "R3");

    // R6 shared vector keeps its flag; R9 software clear
    pulse(7);
    take(16'hFFEC, "R6");
    chk_flags(8'h80, "R6");
    flag_clr_we = 1'b1; flag_clr = 8'h80; tick(1); flag_clr_we = 1'b0; flag_clr = '0;
    chk_flags(8'h00, "R9");

    // R9 same-cycle set beats the clear
    gie = 1'b0;
    src_pulse = 8'h30; tick(1); src_pulse = '0;
    chk_flags(8'h30, "R9");
    flag_clr_we = 1'b1; flag_clr = 8'h30; src_pulse = 8'h10;
    tick(1);
    flag_clr_we = 1'b0; flag_clr = '0; src_pulse = '0;
    chk_flags(8'h10, "R9");
    flag_clr_we = 1'b1; flag_clr = 8'h10; tick(1); flag_clr_we = 1'b0; flag_clr = '0;
    chk_flags(8'h00, "R9");
    gie = 1'b1;

    // R8 no boundary, no entry; a lower request mid-entry waits
    pulse(3);
    tick(4);
    chk_flags(8'h08, "R8");
    a = cyc + 1;
    instr_done = 1'b1;
    expect_entry(a, 16'hFFF4, "R8");
    tick(1);
    instr_done = 1'b0;
    src_pulse[5] = 1'b1;
    tick(1);
    src_pulse = '0;
    tick(7);
    chk_flags(8'h20, "R8");
    take(16'hFFF0, "R8");

    // R7 return pops status then PC
    a = cyc + 1;
    ret_req = 1'b1;
    expect_ev(a,     K_POP_SR, 16'h0, "R7");
    expect_ev(a + 1, K_POP_PC, 16'h0, "R7");
    tick(1); ret_req = 1'b0; tick(3);

    // R7 return ahead of a same-cycle entry
    pulse(1);
    a = cyc + 1;
    ret_req = 1'b1; instr_done = 1'b1;
    expect_ev(a,     K_POP_SR, 16'h0, "R7");
    expect_ev(a + 1, K_POP_PC, 16'h0, "R7");
    tick(1); ret_req = 1'b0; instr_done = 1'b0; tick(3);
    chk_flags(8'h02, "R7");
    take(16'hFFF8, "R7");

    // R10 reset request aborts an entry, request kept
    pulse(2);
    a = cyc + 1;
    instr_done = 1'b1;
    expect_ev(a,     K_PUSH_PC, 16'h0, "R10");
    expect_ev(a + 1, K_PUSH_SR, 16'h0, "R10");
    expect_ev(a + 2, K_SRCLR,   16'h0, "R10");
    expect_ev(a + 2, K_LOAD,    16'hFFFE, "R10");
    tick(1);
    instr_done = 1'b0;
    tick(1);
    rst_req = 1'b1;
    tick(1);
    rst_req = 1'b0;
    tick(3);
    check(busy == 1'b0, "R10", "busy after reset vector", int'(busy), 0);
    chk_flags(8'h04, "R10");
    take(16'hFFF6, "R10");

    tick(3);
    check(exp_q.size() == 0, "R5", "strobes still owed", exp_q.size(), 0);
    finish_run();
  end

endmodule